// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is a 32-pin general-purpose I/O bank for a large chip. A simple register port accepts 32-bit word reads and writes. Software uses it to set each pin's direction and output level. It can make an output pin blink, flip the sense of an input, and read the conditioned input levels. The bank drives pin outputs and output enables. It passes every pin input through a two-flop synchronizer and then applies a per-pin polarity inversion.

Two kinds of interrupt source exist for each pin. A level source is the conditioned input ANDed with a level mask. No latch holds it, so it drops as soon as the input drops. An edge source is a sticky cause bit. A rising transition of the conditioned input sets it, and software clears it by writing zero to that bit. An edge mask gates the sticky cause. For each pin the level and edge terms are ORed together. The pins are then reduced in groups of eight onto four interrupt lines, one per byte of the bank.

Top module: `gpio_irq_bank`

## Requirements
- R1: Word offsets decode as follows: 0x00 output level, 0x04 direction, 0x08 blink enable, 0x0C input polarity, 0x10 conditioned input (read only), 0x14 sticky edge cause, 0x18 edge mask, 0x1C level mask. Reads of output, direction, blink, polarity and both masks return the stored value.
- R2: A direction bit of 1 makes the pin an input, with its output enable low. A direction bit of 0 raises the pin's output enable, and the pin drives its output-level bit.
- R3: Each conditioned-input bit equals the pin level XOR its polarity bit. A pin change is visible there after the second rising clock edge.
- R4: The level source of a pin is the conditioned input AND its level-mask bit, with no latching. When the input returns to inactive, the source drops.
- R5: A 0-to-1 transition of a conditioned-input bit sets its edge-cause bit after the third rising edge from the pin change. A polarity bit of 1 therefore selects falling pin edges.
- R6: A write to the edge-cause offset clears each bit written as 0 and leaves each bit written as 1 unchanged. A new edge arriving in the same cycle wins over the clear.
- R7: Interrupt line g (g = 0..3) is the OR, over pins 8g to 8g+7, of the level source and the edge cause ANDed with the edge mask.
- R8: After reset the output level, blink enable, polarity, edge cause and both masks are zero, and the direction register is all ones, so every pin is an input. All interrupt lines are low.
- R9: An output pin whose blink bit is set drives its output-level bit ANDed with a free-running square wave. The wave has a period of 2^BLINK_DIV_W cycles and is high for half of each period. An output pin without blink drives a steady level.
- R10: Reads at unmapped offsets return zero. Offsets with nonzero low two bits count as unmapped. Writes to the conditioned-input offset or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | PIN_COUNT | Write data |
| busRdata | output | PIN_COUNT | Read data for busAddr (combinational) |
| pinIn | input | PIN_COUNT | Pin input levels (asynchronous) |
| pinOut | output | PIN_COUNT | Pin output levels |
| pinOutEn | output | PIN_COUNT | Pin output enables, 1 = drive |
| irqOut | output | PIN_COUNT/GROUP_SIZE | Grouped interrupt lines |

## Verification
A corrupted edge-cause or mask bit shows up on its group's interrupt line in the same cycle as the fault, and also on the read port. A stale or wrongly inverted synchronizer stage shows up at the conditioned-input offset two edges after a pin change. A missed edge shows up as a cause bit still clear one edge after that. A faulty blink divider changes the count of high cycles seen on a blinking pin within two periods. A faulty direction register flips the output enable at once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_OUT,
    SEL_DIR,
    SEL_BLINK,
    SEL_POL,
    SEL_DIN,
    SEL_CAUSE,
    SEL_EMASK,
    SEL_LMASK
  } rdSel_e;

  typedef struct packed {
    logic   wrOut;
    logic   wrDir;
    logic   wrBlink;
    logic   wrPol;
    logic   wrCause;
    logic   wrEdgeMask;
    logic   wrLvlMask;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = 4;

  logic       mapped;
  logic [2:0] wordIdx;
  logic       doWrite;

  generate
    if (ADDR_W > IDX_HI + 1) begin : g_upper
      assign mapped = (busAddr[1:0] == 2'b00) && (busAddr[ADDR_W-1:IDX_HI+1] == '0);
    end else begin : g_noupper
      assign mapped = (busAddr[1:0] == 2'b00);
    end
  endgenerate

  assign wordIdx = busAddr[IDX_HI:IDX_LO];
  assign doWrite = busValid && busWrite && mapped;

  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_NONE;
    if (mapped) begin
      case (wordIdx)
        3'd0: begin strobe.rdSel = SEL_OUT;   strobe.wrOut      = doWrite; end
        3'd1: begin strobe.rdSel = SEL_DIR;   strobe.wrDir      = doWrite; end
        3'd2: begin strobe.rdSel = SEL_BLINK; strobe.wrBlink    = doWrite; end
        3'd3: begin strobe.rdSel = SEL_POL;   strobe.wrPol      = doWrite; end
        3'd4: begin strobe.rdSel = SEL_DIN;                                end
        3'd5: begin strobe.rdSel = SEL_CAUSE; strobe.wrCause    = doWrite; end
        3'd6: begin strobe.rdSel = SEL_EMASK; strobe.wrEdgeMask = doWrite; end
        default: begin strobe.rdSel = SEL_LMASK; strobe.wrLvlMask = doWrite; end
      endcase
    end
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrOut, strobe.wrDir, strobe.wrBlink, strobe.wrPol,
              strobe.wrCause, strobe.wrEdgeMask, strobe.wrLvlMask})); // R1

  AST_NO_WRITE_UNMAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && !mapped) |->
      !(strobe.wrOut || strobe.wrDir || strobe.wrBlink || strobe.wrPol ||
        strobe.wrCause || strobe.wrEdgeMask || strobe.wrLvlMask)); // R10

endmodule

// File: rtl/gpio_irq_dpath.sv
module gpio_irq_dpath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int BLINK_DIV_W = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  regStrobe_t                        strobe,
  input  logic [PIN_COUNT-1:0]              busWdata,
  output logic [PIN_COUNT-1:0]              busRdata,
  input  logic [PIN_COUNT-1:0]              pinIn,
  output logic [PIN_COUNT-1:0]              pinOut,
  output logic [PIN_COUNT-1:0]              pinOutEn,
  output logic [PIN_COUNT/GROUP_SIZE-1:0]   irqOut
);

  localparam int GROUP_COUNT = PIN_COUNT / GROUP_SIZE;

  logic [PIN_COUNT-1:0] outReg, dirReg, blinkReg, polReg;
  logic [PIN_COUNT-1:0] causeReg, edgeMaskReg, lvlMaskReg;
  logic [PIN_COUNT-1:0] syncStage1, syncStage2, prevDataIn;
  logic [PIN_COUNT-1:0] dataIn, edgeEvent, pinTerm;
  logic [BLINK_DIV_W-1:0] blinkCnt;
  logic blinkWave;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg      <= '0;
      dirReg      <= '1;
      blinkReg    <= '0;
      polReg      <= '0;
      edgeMaskReg <= '0;
      lvlMaskReg  <= '0;
    end else begin
      if (strobe.wrOut)      outReg      <= busWdata;
      if (strobe.wrDir)      dirReg      <= busWdata;
      if (strobe.wrBlink)    blinkReg    <= busWdata;
      if (strobe.wrPol)      polReg      <= busWdata;
      if (strobe.wrEdgeMask) edgeMaskReg <= busWdata;
      if (strobe.wrLvlMask)  lvlMaskReg  <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage1 <= '0;
      syncStage2 <= '0;
      prevDataIn <= '0;
    end else begin
      syncStage1 <= pinIn;
      syncStage2 <= syncStage1;
      prevDataIn <= dataIn;
    end
  end

  assign dataIn    = syncStage2 ^ polReg;
  assign edgeEvent = dataIn & ~prevDataIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReg <= '0;
    end else if (strobe.wrCause) begin
      causeReg <= (causeReg & busWdata) | edgeEvent;
    end else begin
      causeReg <= causeReg | edgeEvent;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blinkCnt <= '0;
    else       blinkCnt <= blinkCnt + 1'b1;
  end

  assign blinkWave = blinkCnt[BLINK_DIV_W-1];

  genvar p;
  generate
    for (p = 0; p < PIN_COUNT; p++) begin : g_pin
      assign pinOut[p]   = blinkReg[p] ? (outReg[p] & blinkWave) : outReg[p];
      assign pinOutEn[p] = ~dirReg[p];
      assign pinTerm[p]  = (dataIn[p] & lvlMaskReg[p]) | (causeReg[p] & edgeMaskReg[p]);
    end
  endgenerate

  genvar g;
  generate
    for (g = 0; g < GROUP_COUNT; g++) begin : g_group
      assign irqOut[g] = |pinTerm[g*GROUP_SIZE +: GROUP_SIZE];
    end
  endgenerate

  always_comb begin
    case (strobe.rdSel)
      SEL_OUT:   busRdata = outReg;
      SEL_DIR:   busRdata = dirReg;
      SEL_BLINK: busRdata = blinkReg;
      SEL_POL:   busRdata = polReg;
      SEL_DIN:   busRdata = dataIn;
      SEL_CAUSE: busRdata = causeReg;
      SEL_EMASK: busRdata = edgeMaskReg;
      SEL_LMASK: busRdata = lvlMaskReg;
      default:   busRdata = '0;
    endcase
  end

  AST_CAUSE_CLEARED_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(causeReg) & ~causeReg)) |-> $past(strobe.wrCause)); // R6

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    ((causeReg & $past(edgeEvent)) == $past(edgeEvent))); // R5

  AST_OE_FOLLOWS_DIR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (pinOutEn != $past(pinOutEn)) |-> $past(strobe.wrDir)); // R2

  AST_IRQ_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    ((edgeMaskReg == '0) && (lvlMaskReg == '0)) |-> (irqOut == '0)); // R7

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PIN_COUNT   = 32,
  parameter int GROUP_SIZE  = 8,
  parameter int BLINK_DIV_W = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busValid,
  input  logic                            busWrite,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [PIN_COUNT-1:0]            busWdata,
  output logic [PIN_COUNT-1:0]            busRdata,
  input  logic [PIN_COUNT-1:0]            pinIn,
  output logic [PIN_COUNT-1:0]            pinOut,
  output logic [PIN_COUNT-1:0]            pinOutEn,
  output logic [PIN_COUNT/GROUP_SIZE-1:0] irqOut
);

  regStrobe_t strobe;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  gpio_irq_dpath #(
    .PIN_COUNT   (PIN_COUNT),
    .GROUP_SIZE  (GROUP_SIZE),
    .BLINK_DIV_W (BLINK_DIV_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

  localparam int ADDR_W = 8;
  localparam int NUM_VEC = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOutEn;
  logic [3:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  // {pins, polarity, level mask, expected data-in, expected irq}
  localparam logic [131:0] VEC [NUM_VEC] = '{
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0000},
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 4'b0001},
    {32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0000},
    {32'h0000_0000, 32'hFF00_0000, 32'h8000_0000, 32'hFF00_0000, 4'b1000},
    {32'h0001_0100, 32'h0000_0000, 32'h0000_0100, 32'h0001_0100, 4'b0010},
    {32'h1234_5678, 32'hFFFF_0000, 32'h0000_0000, 32'hEDCB_5678, 4'b0000},
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int highCnt, steadyCnt;

    waitClk(3);
    rstN = 1'b1;
    waitClk(1);

    // R8 reset state
    regRead(8'h00, rd); check("R8 out", rd, 32'h0);
    regRead(8'h04, rd); check("R8 dir", rd, 32'hFFFF_FFFF);
    regRead(8'h08, rd); check("R8 blink", rd, 32'h0);
    regRead(8'h0C, rd); check("R8 pol", rd, 32'h0);
    regRead(8'h14, rd); check("R8 cause", rd, 32'h0);
    regRead(8'h18, rd); check("R8 emask", rd, 32'h0);
    regRead(8'h1C, rd); check("R8 lmask", rd, 32'h0);
    check("R8 irq", {28'h0, irqOut}, 32'h0);
    check("R8 oe", pinOutEn, 32'h0);

    // R3 R4 R7 vector table (edge mask stays zero)
    for (int i = 0; i < NUM_VEC; i++) begin
      regWrite(8'h0C, VEC[i][99:68]);
      regWrite(8'h1C, VEC[i][67:36]);
      @(negedge clk);
      pinIn = VEC[i][131:100];
      waitClk(2);
      regRead(8'h10, rd);
      check("R3 data-in", rd, VEC[i][35:4]);
      check("R4 R7 irq", {28'h0, irqOut}, {28'h0, VEC[i][3:0]});
    end

    // R1 readback
    regWrite(8'h1C, 32'h0);
    regWrite(8'h18, 32'hA5A5_0F0F);
    regRead(8'h18, rd); check("R1 emask readback", rd, 32'hA5A5_0F0F);
    regWrite(8'h08, 32'h0000_0001);
    regRead(8'h08, rd); check("R1 blink readback", rd, 32'h0000_0001);

    // R5 rising edge latch
    regWrite(8'h18, 32'h0000_0020);
    regWrite(8'h0C, 32'h0);
    waitClk(3);
    regWrite(8'h14, 32'h0);
    regRead(8'h14, rd); check("R6 clear all", rd, 32'h0);
    @(negedge clk);
    pinIn = 32'h0000_0020;
    waitClk(2);
    regRead(8'h14, rd); check("R5 not yet", rd, 32'h0);
    waitClk(1);
    regRead(8'h14, rd); check("R5 rising latched", rd, 32'h0000_0020);
    check("R7 edge irq group0", {28'h0, irqOut}, 32'h1);
    @(negedge clk);
    pinIn = 32'h0;
    waitClk(4);
    regRead(8'h14, rd); check("R5 sticky after fall", rd, 32'h0000_0020);

    // R6 write-one keeps, write-zero clears
    regWrite(8'h14, 32'hFFFF_FFFF);
    regRead(8'h14, rd); check("R6 write one keeps", rd, 32'h0000_0020);
    regWrite(8'h14, 32'hFFFF_FFDF);
    regRead(8'h14, rd); check("R6 write zero clears", rd, 32'h0);
    check("R6 irq dropped", {28'h0, irqOut}, 32'h0);

    // R5 falling edge via polarity
    @(negedge clk);
    pinIn = 32'h0000_0020;
    waitClk(4);
    regWrite(8'h0C, 32'h0000_0020);
    regWrite(8'h14, 32'h0);
    waitClk(2);
    regRead(8'h14, rd); check("R5 no edge on high", rd, 32'h0);
    @(negedge clk);
    pinIn = 32'h0;
    waitClk(3);
    regRead(8'h14, rd); check("R5 falling latched", rd, 32'h0000_0020);

    // R7 group isolation with edge mask on pin 20
    regWrite(8'h0C, 32'h0);
    regWrite(8'h18, 32'h0010_0000);
    regWrite(8'h14, 32'h0);
    @(negedge clk);
    pinIn = 32'h0010_0000;
    waitClk(3);
    check("R7 group2 only", {28'h0, irqOut}, 32'h4);

    // R2 direction and output enable
    regWrite(8'h00, 32'h0000_0005);
    regWrite(8'h04, 32'hFFFF_FFF0);
    check("R2 oe", pinOutEn, 32'h0000_000F);
    check("R2 out value", pinOut & pinOutEn, 32'h0000_0005);

    // R9 blink on pin 0 (blink bit set earlier), steady on pin 2
    highCnt = 0; steadyCnt = 0;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      if (pinOut[0]) highCnt++;
      if (pinOut[2]) steadyCnt++;
    end
    check("R9 blink high cycles", highCnt, 16);
    check("R9 steady pin", steadyCnt, 32);

    // R10 unmapped and read-only
    regRead(8'h20, rd); check("R10 unmapped read", rd, 32'h0);
    regRead(8'h01, rd); check("R10 misaligned read", rd, 32'h0);
    regRead(8'h10, rd); check("R10 data-in before", rd, 32'h0010_0000);
    regWrite(8'h10, 32'h0);
    regWrite(8'h20, 32'hFFFF_FFFF);
    regWrite(8'h01, 32'hFFFF_FFFF);
    regRead(8'h10, rd); check("R10 data-in unchanged", rd, 32'h0010_0000);
    regRead(8'h00, rd); check("R10 out unchanged", rd, 32'h0000_0005);
    regRead(8'h04, rd); check("R10 dir unchanged", rd, 32'hFFFF_FFF0);
    regRead(8'h0C, rd); check("R10 pol unchanged", rd, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule